// File: doc/BRIEF.md
# Cascade Interlock Controller for FIFO Slices

This controller lets a row of identical FIFO slices act as one wide FIFO with no gating logic between them. Each slice works out its own role while reset is held. The slice whose chain-enable input is tied low becomes the row master. Every other slice becomes a slave. Each slave's chain-enable input comes from the input-full flag of the slice just upstream of it. During reset every slice drives that flag high, so only the tied slice sees a low enable.

After reset, a shared load-to-stack request arms every slice at once. The master then initializes its input register. Each slave waits for its upstream neighbour's flag to drop before it does the same, so the initialization ripples along the row one slice per clock. The last slice's flag therefore speaks for the whole row. The output side works the same way. A shift-out or parallel-out request arms every slice. The master reloads its output register from the stack and raises its ready flag. Each slave waits for its upstream ready flag before it does the same.

The block has no data path. It carries only control and status levels, so no stream handshake applies at its edge. All inputs are sampled on the rising edge of one clock. Reset is synchronous and active low.

Top module: `fifo_interlock_slice`

## Requirements
- R1: While `mrst_n` is low at a rising edge, after that edge `irf`=1, `ore`=0, `in_init`=0 and `out_load`=0, and any armed request is discarded.
- R2: At each reset edge the slice latches its role: master if `ies_n` is 0, slave if 1. The role holds until the next reset, whatever `ies_n` does afterwards.
- R3: On a master, `tts_n`=0 sampled at edge k arms a request. At edge k+1, `in_init` pulses to 1 and `irf` drops to 0.
- R4: On a slave, an armed input request fires (`in_init`=1, `irf`=0) at the first edge where `ies_n` is 0, and never before.
- R5: Each armed request gives exactly one `in_init` pulse. After that, `irf` stays 0 until `in_full`=1 is sampled, and goes to 1 at that edge. If a request fires at the same edge, the firing wins.
- R6: If `tts_n`=0 is sampled at the same edge where a request fires, the slice stays armed and fires again later.
- R7: On a master, `tos`=1 or `top`=1 sampled at edge k arms an output request. At edge k+1, `out_load` pulses to 1 and `ore` goes to 1.
- R8: On a slave, an armed output request fires (`out_load`=1, `ore`=1) at the first edge where `oes` is 1, and never before.
- R9: `ore` goes to 0 at an edge where `out_shifted`=1 is sampled. If an output request fires at the same edge, the load wins and `ore` stays 1.
- R10: `in_full` sampled while `irf`=1 leaves `irf` at 1. `out_shifted` sampled while `ore`=0 leaves `ore` at 0.
- R11: In a three-slice row (slice 0 master with `ies_n` tied low; slice i+1 takes `ies_n` from slice i's `irf` and `oes` from slice i's `ore`), `in_init` and `out_load` reach slices 0, 1 and 2 on consecutive edges, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| mrst_n | input | 1 | Synchronous master reset, active low |
| ies_n | input | 1 | Input chain enable, active low (tied low on the master, upstream `irf` on a slave) |
| oes | input | 1 | Output chain enable, active high (upstream `ore` on a slave, unused on the master) |
| tts_n | input | 1 | Load-to-stack request, active low level |
| tos | input | 1 | Serial shift-out request, active high level |
| top | input | 1 | Parallel output request, active high level |
| in_full | input | 1 | Local input register has filled |
| out_shifted | input | 1 | Local output register has been emptied by a shift-out |
| irf | output | 1 | Input register full flag |
| ore | output | 1 | Output register ready flag |
| in_init | output | 1 | One-cycle strobe that initializes the input register |
| out_load | output | 1 | One-cycle strobe that loads the output register from the stack |

## Verification
Two functions on one slice can land on the same edge: an output request firing and a shift-out emptying the register. They are forced together in two ways. In the first, a master is re-armed and receives `out_shifted` in the same cycle it reloads. In the second, a slave fires in the same cycle its upstream neighbour is shifted empty. The result is judged by checking that `ore` stays high on the loading slice while the emptied neighbour clears. A second such pair is a new load-to-stack request arriving as a pending one fires on the master. That one is judged by a second `in_init` pulse on the next edge.

// File: rtl/fil_pkg.sv
package fil_pkg;
  // Role taken by a slice during reset.
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;
endpackage

// File: rtl/fil_role_latch.sv
module fil_role_latch
  import fil_pkg::*;
(
  input  logic  clk,
  input  logic  mrst_n,
  input  logic  ies_n,
  output role_e role
);
  // The role follows the chain enable while reset is held and freezes once it lifts.
  always_ff @(posedge clk) begin
    if (!mrst_n) role <= ies_n ? ROLE_SLAVE : ROLE_MASTER;
  end
endmodule

// File: rtl/fil_in_ctl.sv
module fil_in_ctl (
  input  logic clk,
  input  logic mrst_n,
  input  logic is_master,
  input  logic ies_n,
  input  logic tts_n,
  input  logic in_full,
  output logic pend,
  output logic irf,
  output logic init_stb
);
  logic go;

  // An armed request fires at once on a master, or when the upstream flag drops on a slave.
  assign go = pend & (is_master | ~ies_n);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      pend     <= 1'b0;
      irf      <= 1'b1;
      init_stb <= 1'b0;
    end else begin
      init_stb <= go;
      // A new request that arrives while one fires keeps the slice armed.
      pend     <= ~tts_n | (pend & ~go);
      if (go)           irf <= 1'b0;
      else if (in_full) irf <= 1'b1;
    end
  end
endmodule

// File: rtl/fil_out_ctl.sv
module fil_out_ctl (
  input  logic clk,
  input  logic mrst_n,
  input  logic is_master,
  input  logic oes,
  input  logic tos,
  input  logic top,
  input  logic out_shifted,
  output logic pend,
  output logic ore,
  output logic load_stb
);
  logic go;

  assign go = pend & (is_master | oes);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      pend     <= 1'b0;
      ore      <= 1'b0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= go;
      pend     <= tos | top | (pend & ~go);
      // A reload beats an emptying shift-out in the same cycle.
      if (go)               ore <= 1'b1;
      else if (out_shifted) ore <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_interlock_slice.sv
module fifo_interlock_slice
  import fil_pkg::*;
(
  input  logic clk,
  input  logic mrst_n,
  input  logic ies_n,
  input  logic oes,
  input  logic tts_n,
  input  logic tos,
  input  logic top,
  input  logic in_full,
  input  logic out_shifted,
  output logic irf,
  output logic ore,
  output logic in_init,
  output logic out_load
);
  role_e role;
  logic  role_master;
  logic  in_pend;
  logic  out_pend;

  fil_role_latch u_role (
    .clk    (clk),
    .mrst_n (mrst_n),
    .ies_n  (ies_n),
    .role   (role)
  );

  assign role_master = (role == ROLE_MASTER);

  fil_in_ctl u_in (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .is_master (role_master),
    .ies_n     (ies_n),
    .tts_n     (tts_n),
    .in_full   (in_full),
    .pend      (in_pend),
    .irf       (irf),
    .init_stb  (in_init)
  );

  fil_out_ctl u_out (
    .clk         (clk),
    .mrst_n      (mrst_n),
    .is_master   (role_master),
    .oes         (oes),
    .tos         (tos),
    .top         (top),
    .out_shifted (out_shifted),
    .pend        (out_pend),
    .ore         (ore),
    .load_stb    (out_load)
  );
endmodule

// File: rtl/fifo_interlock_slice_chk.sv
module fifo_interlock_slice_chk (
  input logic clk,
  input logic mrst_n,
  input logic ies_n,
  input logic oes,
  input logic in_full,
  input logic out_shifted,
  input logic master,
  input logic in_req,
  input logic out_req,
  input logic irf,
  input logic ore,
  input logic in_init,
  input logic out_load
);
  // R2: the role does not move between resets
  assert_role_held_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(master));

  // R3: an armed master initializes on the next edge
  assert_master_init_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (master && in_req) |=> (in_init && !irf));

  // R4: a slave initializes only after seeing its enable low
  assert_slave_waits_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    (in_init && !master) |-> $past(!ies_n));

  // R5: an init strobe always comes with the full flag low
  assert_init_clears_irf_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    in_init |-> !irf);

  // R5: the full flag rises only on a reported fill
  assert_irf_rise_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(irf) |-> $past(in_full));

  // R7: an armed master reloads on the next edge
  assert_master_load_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (master && out_req) |=> (out_load && ore));

  // R8: a slave reloads only after seeing its enable high
  assert_slave_load_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    (out_load && !master) |-> $past(oes));

  // R9: the ready flag falls only after a shift-out
  assert_ore_fall_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    $fell(ore) |-> $past(out_shifted));
endmodule

bind fifo_interlock_slice fifo_interlock_slice_chk u_chk (
  .clk         (clk),
  .mrst_n      (mrst_n),
  .ies_n       (ies_n),
  .oes         (oes),
  .in_full     (in_full),
  .out_shifted (out_shifted),
  .master      (role_master),
  .in_req      (in_pend),
  .out_req     (out_pend),
  .irf         (irf),
  .ore         (ore),
  .in_init     (in_init),
  .out_load    (out_load)
);

// File: tb/fifo_interlock_slice_bench.sv
module fifo_interlock_slice_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  // Fields: tag[24:21] tts_n[20] tos[19] top[18] in_full[17:15] shifted[14:12]
  //         exp irf[11:9] exp ore[8:6] exp init[5:3] exp load[2:0]; bit i = slice i
  localparam logic [24:0] VEC [NV] = '{
    {4'd3,  1'b0,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R3 arm
    {4'd3,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b110,3'b000,3'b001,3'b000}, // R3 master fires
    {4'd4,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b100,3'b000,3'b010,3'b000}, // R4 slave 1
    {4'd11, 1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b000,3'b000,3'b100,3'b000}, // R11 slave 2 last
    {4'd5,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b000,3'b000,3'b000,3'b000}, // R5 single pulse
    {4'd5,  1'b1,1'b0,1'b0, 3'b001,3'b000, 3'b001,3'b000,3'b000,3'b000}, // R5 fill slice 0
    {4'd5,  1'b1,1'b0,1'b0, 3'b110,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R5 fill rest
    {4'd10, 1'b1,1'b0,1'b0, 3'b001,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R10 fill ignored
    {4'd7,  1'b1,1'b1,1'b0, 3'b000,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R7 arm by tos
    {4'd7,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b001,3'b000,3'b001}, // R7 master loads
    {4'd8,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b011,3'b000,3'b010}, // R8 slave 1
    {4'd11, 1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b111,3'b000,3'b100}, // R11 slave 2 last
    {4'd7,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b111,3'b000,3'b000}, // R7 single pulse
    {4'd9,  1'b1,1'b0,1'b0, 3'b000,3'b111, 3'b111,3'b000,3'b000,3'b000}, // R9 all shifted
    {4'd7,  1'b1,1'b0,1'b1, 3'b000,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R7 arm by top
    {4'd7,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b001,3'b000,3'b001}, // R7
    {4'd8,  1'b1,1'b0,1'b0, 3'b000,3'b001, 3'b111,3'b010,3'b000,3'b010}, // R8 load while upstream empties
    {4'd8,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b110,3'b000,3'b100}, // R8
    {4'd9,  1'b1,1'b0,1'b0, 3'b000,3'b110, 3'b111,3'b000,3'b000,3'b000}, // R9
    {4'd10, 1'b1,1'b0,1'b0, 3'b000,3'b001, 3'b111,3'b000,3'b000,3'b000}, // R10 shift ignored
    {4'd6,  1'b0,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R6 arm
    {4'd6,  1'b0,1'b0,1'b0, 3'b000,3'b000, 3'b110,3'b000,3'b001,3'b000}, // R6 re-arm while firing
    {4'd6,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b100,3'b000,3'b011,3'b000}, // R6 second pulse
    {4'd4,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b000,3'b000,3'b100,3'b000}, // R4
    {4'd5,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b000,3'b000,3'b000,3'b000}, // R5
    {4'd5,  1'b1,1'b0,1'b0, 3'b111,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R5
    {4'd7,  1'b1,1'b1,1'b0, 3'b000,3'b000, 3'b111,3'b000,3'b000,3'b000}, // R7 arm
    {4'd7,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b001,3'b000,3'b001}, // R7
    {4'd9,  1'b1,1'b1,1'b0, 3'b000,3'b001, 3'b111,3'b010,3'b000,3'b010}, // R9 shift, re-arm
    {4'd9,  1'b1,1'b0,1'b0, 3'b000,3'b001, 3'b111,3'b111,3'b000,3'b101}, // R9 load beats shift
    {4'd8,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b111,3'b000,3'b010}, // R8
    {4'd7,  1'b1,1'b0,1'b0, 3'b000,3'b000, 3'b111,3'b111,3'b000,3'b000}, // R7
    {4'd9,  1'b1,1'b0,1'b0, 3'b000,3'b111, 3'b111,3'b000,3'b000,3'b000}  // R9
  };

  logic clk = 1'b0;
  logic mrst_n = 1'b0;
  logic tts_n = 1'b1;
  logic tos = 1'b0;
  logic top = 1'b0;
  logic [2:0] in_full = '0;
  logic [2:0] shifted = '0;
  logic [2:0] irf, ore, init, load;
  logic solo_ies_n = 1'b1;
  logic solo_tts_n = 1'b1;
  logic solo_irf, solo_ore, solo_init, solo_load;
  int applied = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_interlock_slice u_fifo_interlock_slice (
    .clk(clk), .mrst_n(mrst_n), .ies_n(1'b0), .oes(1'b0), .tts_n(tts_n),
    .tos(tos), .top(top), .in_full(in_full[0]), .out_shifted(shifted[0]),
    .irf(irf[0]), .ore(ore[0]), .in_init(init[0]), .out_load(load[0]));

  fifo_interlock_slice u_slice1 (
    .clk(clk), .mrst_n(mrst_n), .ies_n(irf[0]), .oes(ore[0]), .tts_n(tts_n),
    .tos(tos), .top(top), .in_full(in_full[1]), .out_shifted(shifted[1]),
    .irf(irf[1]), .ore(ore[1]), .in_init(init[1]), .out_load(load[1]));

  fifo_interlock_slice u_slice2 (
    .clk(clk), .mrst_n(mrst_n), .ies_n(irf[1]), .oes(ore[1]), .tts_n(tts_n),
    .tos(tos), .top(top), .in_full(in_full[2]), .out_shifted(shifted[2]),
    .irf(irf[2]), .ore(ore[2]), .in_init(init[2]), .out_load(load[2]));

  fifo_interlock_slice u_solo (
    .clk(clk), .mrst_n(mrst_n), .ies_n(solo_ies_n), .oes(1'b0), .tts_n(solo_tts_n),
    .tos(1'b0), .top(1'b0), .in_full(1'b0), .out_shifted(1'b0),
    .irf(solo_irf), .ore(solo_ore), .in_init(solo_init), .out_load(solo_load));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] act;
    logic seen;
    // R1: reset state of the whole row
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    act = {irf, ore, init, load};
    check(act === 12'b111_000_000_000, "R1", "reset flags", act, 12'b111_000_000_000);
    @(negedge clk);
    mrst_n = 1'b1;

    // Vector walk over the three-slice row (R3..R11)
    for (int i = 0; i < NV; i++) begin
      tts_n   = VEC[i][20];
      tos     = VEC[i][19];
      top     = VEC[i][18];
      in_full = VEC[i][17:15];
      shifted = VEC[i][14:12];
      @(posedge clk);
      #(CLK_PERIOD/4);
      act = {irf, ore, init, load};
      check(act === VEC[i][11:0], $sformatf("R%0d", VEC[i][24:21]),
            $sformatf("vector %0d", i), act, VEC[i][11:0]);
      @(negedge clk);
    end
    tts_n = 1'b1; tos = 1'b0; top = 1'b0; in_full = '0; shifted = '0;

    // R2: solo slice was reset with its enable high, so it is a slave and waits
    solo_tts_n = 1'b0;
    @(negedge clk);
    solo_tts_n = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      seen = seen | solo_init | ~solo_irf;
    end
    check(!seen, "R2", "slave held back", {11'd0, seen}, 12'd0);
    @(negedge clk);
    solo_ies_n = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(solo_init === 1'b1 && solo_irf === 1'b0, "R4", "slave fires on enable",
          {10'd0, solo_init, solo_irf}, 12'b10);

    // R1: reset lands on the edge where armed requests would fire
    @(negedge clk);
    tts_n = 1'b0; tos = 1'b1;
    @(negedge clk);
    tts_n = 1'b1; tos = 1'b0; mrst_n = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    act = {irf, ore, init, load};
    check(act === 12'b111_000_000_000, "R1", "reset wins over firing", act, 12'b111_000_000_000);
    @(negedge clk);
    @(negedge clk);
    mrst_n = 1'b1;
    solo_ies_n = 1'b1;
    seen = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      seen = seen | (|init) | (|load);
    end
    check(!seen, "R1", "requests discarded by reset", {11'd0, seen}, 12'd0);

    // R2: solo was reset with its enable low, so it acts as master despite enable now high
    @(negedge clk);
    solo_tts_n = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(solo_init === 1'b0, "R2", "master arm edge", {11'd0, solo_init}, 12'd0);
    @(negedge clk);
    solo_tts_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(solo_init === 1'b1 && solo_irf === 1'b0, "R2", "role held as master",
          {10'd0, solo_init, solo_irf}, 12'b10);

    @(negedge clk);
    finish_run();
  end
endmodule